// File: doc/BRIEF.md
# Multiplexed-Bus Dual-Port Byte Memory

This block is a 256-byte memory shared by two independent ports, A and B. Each port has one 8-bit bus that carries an address first and then data. Each port also has three active-low controls: an enable, a write strobe and a read strobe. The pins are asynchronous to the block. The block samples them with its own clock, passes the controls through synchronizer stages, and detects control edges in logic.

A port cycle starts when the enable falls. That edge latches the address from the bus. The host then either pulls the read strobe low, and the block drives the stored byte back on the bus, or pulls the write strobe low and presents the data byte. A write is committed when the enable or the write strobe rises, whichever comes first. Both ports reach every location.

Two collision rules are fixed. When both ports commit to the same address in the same cycle, port A's byte is kept. When one port reads a location in the same cycle that the other port writes it, the read shows the previous byte. Asserting the read and write strobes together is a protocol error: the port does nothing and raises a sticky flag.

Top module: `mxbus_dpram`

## Requirements
- R1: After reset, ad_oe_a, ad_oe_b, err_a and err_b are 0 and every one of the 256 bytes reads as 0x00. A reset also clears a raised error flag.
- R2: The bus value sampled on the clock where a port's en_n is first seen low becomes that port's address. Later values on the bus do not change the address of the cycle.
- R3: With en_n and wr_n both low and rd_n high, the byte stored is the one on the bus at the last clock before en_n or wr_n rises. Either signal rising first ends the write. A bus change made together with the rising strobe is not stored.
- R4: ad_oe_x is 1 only while en_n and rd_n are both low and wr_n is high, observed three clocks later. While it is 1, ad_out_x carries the byte at the latched address. ad_oe_x returns to 0 once either en_n or rd_n rises.
- R5: Each port can write and read every address, including 0x00 and 0xFF. A byte written through one port is read back through the other.
- R6: Both ports can read the same address at the same time, and each gets the stored byte.
- R7: When both ports commit writes to the same address in the same clock cycle, the byte from port A is kept. Same-cycle writes to different addresses both take effect.
- R8: The memory write for a commit happens three clocks after the strobe rises at the pins. A port already reading that address shows the old byte for one more clock and the new byte from the clock after.
- R9: If rd_n and wr_n of a port are low at the same time, that port stores nothing and never raises ad_oe. Its err flag goes to 1 and stays 1 until reset. The other port's flag is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_in_a | input | 8 | Port A bus value seen at the pins (address, then write data) |
| ad_out_a | output | 8 | Port A read data, 0 when not driving |
| ad_oe_a | output | 1 | Port A bus drive enable for the read-data phase |
| en_n_a | input | 1 | Port A enable, active low |
| wr_n_a | input | 1 | Port A write strobe, active low |
| rd_n_a | input | 1 | Port A read strobe, active low |
| err_a | output | 1 | Port A sticky protocol-error flag |
| ad_in_b | input | 8 | Port B bus value seen at the pins |
| ad_out_b | output | 8 | Port B read data, 0 when not driving |
| ad_oe_b | output | 1 | Port B bus drive enable |
| en_n_b | input | 1 | Port B enable, active low |
| wr_n_b | input | 1 | Port B write strobe, active low |
| rd_n_b | input | 1 | Port B read strobe, active low |
| err_b | output | 1 | Port B sticky protocol-error flag |

## Verification
Writes are tried with both endings, the enable rising first and the write strobe rising first. In each case the bus is changed together with the rising strobe, which shows whether data is taken from the clock before the end or from the end itself. Reads replace the address with a different value right after the enable falls, which separates a latched address from a live one. Reads and writes cross between ports at addresses 0x00 and 0xFF. Concurrent patterns cover a shared read, same- and different-address same-cycle writes, and a write landing under an open read, where the old-then-new timing is checked cycle by cycle. A strobe clash on one port shows that the write is suppressed, the bus is not driven, and the flag is confined to that port and cleared by reset.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NPORTS = 2;

    // control strobes, active high after inversion of the pins
    typedef struct packed {
        logic en;
        logic wr;
        logic rd;
    } ctrl_t;

    // write request leaving a port toward the storage array
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wreq_t;

    function automatic ctrl_t ctrl_from_pins(input logic en_n, input logic wr_n,
                                             input logic rd_n);
        ctrl_t c;
        c.en = ~en_n;
        c.wr = ~wr_n;
        c.rd = ~rd_n;
        return c;
    endfunction
endpackage

// File: rtl/mxb_pipe.sv
module mxb_pipe #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[0] <= '0;
                else     stage[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= '0;
                else     stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/mxb_port.sv
module mxb_port
    import mxb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl_raw,
    input  logic [DATA_W-1:0] bus_raw,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output wreq_t             wreq,
    output logic              drive,
    output logic [DATA_W-1:0] bus_out,
    output logic              err
);
    localparam int CW = $bits(ctrl_t);

    ctrl_t             c;
    logic [CW-1:0]     c_bits;
    logic [DATA_W-1:0] bus_s;
    logic              en_prev;
    logic              wph_prev;
    logic [DATA_W-1:0] data_q;
    logic              wph;
    logic              rph;
    logic              clash;

    // controls are synchronized, bus is delayed by the same depth to stay aligned
    mxb_pipe #(.W(CW), .STAGES(STAGES)) u_ctrl_sync (
        .clk(clk), .rst(rst), .d(ctrl_raw), .q(c_bits)
    );
    mxb_pipe #(.W(DATA_W), .STAGES(STAGES)) u_bus_dly (
        .clk(clk), .rst(rst), .d(bus_raw), .q(bus_s)
    );

    assign c     = ctrl_t'(c_bits);
    assign wph   = c.en & c.wr & ~c.rd;
    assign rph   = c.en & c.rd & ~c.wr;
    assign clash = c.wr & c.rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_prev  <= 1'b0;
            wph_prev <= 1'b0;
            addr     <= '0;
            data_q   <= '0;
            drive    <= 1'b0;
            err      <= 1'b0;
        end else begin
            en_prev  <= c.en;
            wph_prev <= wph;
            if (c.en && !en_prev) addr <= bus_s;
            if (wph)              data_q <= bus_s;
            drive <= rph;
            if (clash)            err <= 1'b1;
        end
    end

    // commit when the write phase ends because enable or write strobe released
    always_comb begin
        wreq.vld  = wph_prev & ~(c.en & c.wr);
        wreq.addr = addr;
        wreq.data = data_q;
    end

    assign bus_out = drive ? rdata : '0;
endmodule

// File: rtl/mxb_mem.sv
module mxb_mem
    import mxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wreq_t             wreq  [NPORTS],
    input  logic [ADDR_W-1:0] raddr [NPORTS],
    output logic [DATA_W-1:0] rdata [NPORTS]
);
    logic [DATA_W-1:0] cells [DEPTH];

    // highest index applied first so port 0 (A) overrides on equal addresses
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else begin
            for (int p = NPORTS - 1; p >= 0; p--) begin
                if (wreq[p].vld) cells[wreq[p].addr] <= wreq[p].data;
            end
        end
    end

    // registered read: a same-cycle write is seen one clock later
    for (genvar rp = 0; rp < NPORTS; rp++) begin : g_rd
        always_ff @(posedge clk) begin
            if (rst) rdata[rp] <= '0;
            else     rdata[rp] <= cells[raddr[rp]];
        end
    end
endmodule

// File: rtl/mxbus_dpram.sv
module mxbus_dpram
    import mxb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] ad_in_a,
    output logic [DATA_W-1:0] ad_out_a,
    output logic              ad_oe_a,
    input  logic              en_n_a,
    input  logic              wr_n_a,
    input  logic              rd_n_a,
    output logic              err_a,
    input  logic [DATA_W-1:0] ad_in_b,
    output logic [DATA_W-1:0] ad_out_b,
    output logic              ad_oe_b,
    input  logic              en_n_b,
    input  logic              wr_n_b,
    input  logic              rd_n_b,
    output logic              err_b
);
    ctrl_t             pin_ctrl [NPORTS];
    logic [DATA_W-1:0] pin_bus  [NPORTS];
    logic [DATA_W-1:0] out_bus  [NPORTS];
    logic              out_oe   [NPORTS];
    logic              out_err  [NPORTS];
    wreq_t             wreq     [NPORTS];
    logic [ADDR_W-1:0] raddr    [NPORTS];
    logic [DATA_W-1:0] rdata    [NPORTS];

    assign pin_ctrl[0] = ctrl_from_pins(en_n_a, wr_n_a, rd_n_a);
    assign pin_ctrl[1] = ctrl_from_pins(en_n_b, wr_n_b, rd_n_b);
    assign pin_bus[0]  = ad_in_a;
    assign pin_bus[1]  = ad_in_b;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        mxb_port #(.STAGES(SYNC_STAGES)) u_port (
            .clk      (clk),
            .rst      (rst),
            .ctrl_raw (pin_ctrl[p]),
            .bus_raw  (pin_bus[p]),
            .rdata    (rdata[p]),
            .addr     (raddr[p]),
            .wreq     (wreq[p]),
            .drive    (out_oe[p]),
            .bus_out  (out_bus[p]),
            .err      (out_err[p])
        );
    end

    mxb_mem u_mem (
        .clk   (clk),
        .rst   (rst),
        .wreq  (wreq),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign ad_out_a = out_bus[0];
    assign ad_oe_a  = out_oe[0];
    assign err_a    = out_err[0];
    assign ad_out_b = out_bus[1];
    assign ad_oe_b  = out_oe[1];
    assign err_b    = out_err[1];
endmodule

// File: rtl/mxbus_dpram_chk.sv
module mxbus_dpram_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst,
    input logic ad_oe_a,
    input logic en_n_a,
    input logic wr_n_a,
    input logic rd_n_a,
    input logic err_a,
    input logic ad_oe_b,
    input logic en_n_b,
    input logic wr_n_b,
    input logic rd_n_b,
    input logic err_b
);
    localparam int LAT = SYNC_STAGES + 1;

    // R4: drive only follows a clean read phase at the pins
    p_drive_needs_read_r4_a: assert property (@(posedge clk) disable iff (rst)
        ad_oe_a |-> ($past(en_n_a, LAT) == 1'b0 && $past(rd_n_a, LAT) == 1'b0
                     && $past(wr_n_a, LAT) == 1'b1));
    p_drive_needs_read_r4_b: assert property (@(posedge clk) disable iff (rst)
        ad_oe_b |-> ($past(en_n_b, LAT) == 1'b0 && $past(rd_n_b, LAT) == 1'b0
                     && $past(wr_n_b, LAT) == 1'b1));

    // R9: error flag is sticky until reset
    p_err_sticky_r9_a: assert property (@(posedge clk) disable iff (rst)
        err_a |=> err_a);
    p_err_sticky_r9_b: assert property (@(posedge clk) disable iff (rst)
        err_b |=> err_b);

    // R9: error flag only rises after a strobe clash at the pins
    p_err_cause_r9_a: assert property (@(posedge clk) disable iff (rst)
        $rose(err_a) |-> ($past(wr_n_a, LAT) == 1'b0 && $past(rd_n_a, LAT) == 1'b0));
    p_err_cause_r9_b: assert property (@(posedge clk) disable iff (rst)
        $rose(err_b) |-> ($past(wr_n_b, LAT) == 1'b0 && $past(rd_n_b, LAT) == 1'b0));
endmodule

bind mxbus_dpram mxbus_dpram_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk(clk), .rst(rst),
    .ad_oe_a(ad_oe_a), .en_n_a(en_n_a), .wr_n_a(wr_n_a), .rd_n_a(rd_n_a), .err_a(err_a),
    .ad_oe_b(ad_oe_b), .en_n_b(en_n_b), .wr_n_b(wr_n_b), .rd_n_b(rd_n_b), .err_b(err_b)
);

// File: tb/mxbus_dpram_tb.sv
module mxbus_dpram_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ad_in [2];
    logic       en_n  [2];
    logic       wr_n  [2];
    logic       rd_n  [2];
    logic [7:0] ad_out [2];
    logic       ad_oe  [2];
    logic       err    [2];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mxbus_dpram u_dut (
        .clk(clk), .rst(rst),
        .ad_in_a(ad_in[0]), .ad_out_a(ad_out[0]), .ad_oe_a(ad_oe[0]),
        .en_n_a(en_n[0]), .wr_n_a(wr_n[0]), .rd_n_a(rd_n[0]), .err_a(err[0]),
        .ad_in_b(ad_in[1]), .ad_out_b(ad_out[1]), .ad_oe_b(ad_oe[1]),
        .en_n_b(en_n[1]), .wr_n_b(wr_n[1]), .rd_n_b(rd_n[1]), .err_b(err[1])
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        for (int p = 0; p < 2; p++) begin
            ad_in[p] = 8'h00; en_n[p] = 1'b1; wr_n[p] = 1'b1; rd_n[p] = 1'b1;
        end
        idle(4);
        rst = 1'b0;
        idle(2);
    endtask

    // write: en falls with address, data replaces it; ce_first picks which strobe ends it
    task automatic do_write(input int p, input logic [7:0] a, input logic [7:0] d,
                            input bit ce_first);
        @(negedge clk);
        ad_in[p] = a; en_n[p] = 1'b0;
        @(negedge clk);
        ad_in[p] = d; wr_n[p] = 1'b0;
        idle(3);
        ad_in[p] = ~d;                       // changed with the ending edge: must not be stored
        if (ce_first) en_n[p] = 1'b1; else wr_n[p] = 1'b1;
        @(negedge clk);
        en_n[p] = 1'b1; wr_n[p] = 1'b1;
        idle(4);
    endtask

    // read: address is replaced by junk right after en falls
    task automatic do_read(input int p, input logic [7:0] a, input logic [7:0] exp,
                           input string req);
        @(negedge clk);
        ad_in[p] = a; en_n[p] = 1'b0;
        @(negedge clk);
        ad_in[p] = ~a; rd_n[p] = 1'b0;
        idle(4);
        chk({req, " drive"}, {7'b0, ad_oe[p]}, 8'h01);
        chk({req, " data"}, ad_out[p], exp);
        rd_n[p] = 1'b1;
        idle(4);
        chk({req, " release"}, {7'b0, ad_oe[p]}, 8'h00);
        en_n[p] = 1'b1;
        idle(2);
    endtask

    task automatic t_reset();
        chk("R1 oe_a", {7'b0, ad_oe[0]}, 8'h00);
        chk("R1 oe_b", {7'b0, ad_oe[1]}, 8'h00);
        chk("R1 err_a", {7'b0, err[0]}, 8'h00);
        chk("R1 err_b", {7'b0, err[1]}, 8'h00);
        do_read(0, 8'hFF, 8'h00, "R1 clear ff");
        do_read(1, 8'h00, 8'h00, "R1 clear 00");
    endtask

    task automatic t_cross();
        do_write(0, 8'h10, 8'h3C, 1'b0);
        do_read(1, 8'h10, 8'h3C, "R3 we-end R2 R5 A->B");
        do_write(1, 8'hFF, 8'hA5, 1'b1);
        do_read(0, 8'hFF, 8'hA5, "R3 ce-end R5 B->A ff");
        do_write(0, 8'h00, 8'h81, 1'b1);
        do_read(1, 8'h00, 8'h81, "R5 addr 00");
        do_read(0, 8'h10, 8'h3C, "R4 R2 unchanged");
    endtask

    task automatic t_dual_read();
        fork
            do_read(0, 8'h10, 8'h3C, "R6 port A");
            do_read(1, 8'h10, 8'h3C, "R6 port B");
        join
    endtask

    task automatic t_ww();
        fork
            do_write(0, 8'h40, 8'h11, 1'b0);
            do_write(1, 8'h40, 8'h22, 1'b0);
        join
        do_read(1, 8'h40, 8'h11, "R7 same addr A wins");
        fork
            do_write(0, 8'h41, 8'h5E, 1'b1);
            do_write(1, 8'h42, 8'h6F, 1'b1);
        join
        do_read(0, 8'h42, 8'h6F, "R7 diff addr B");
        do_read(1, 8'h41, 8'h5E, "R7 diff addr A");
    endtask

    task automatic t_rw();
        do_write(0, 8'h50, 8'h77, 1'b0);
        @(negedge clk);
        ad_in[1] = 8'h50; en_n[1] = 1'b0;
        @(negedge clk);
        ad_in[1] = 8'h00; rd_n[1] = 1'b0;
        idle(4);
        chk("R8 open read", ad_out[1], 8'h77);
        ad_in[0] = 8'h50; en_n[0] = 1'b0;
        @(negedge clk);
        ad_in[0] = 8'h99; wr_n[0] = 1'b0;
        idle(3);
        wr_n[0] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 old in commit cycle", ad_out[1], 8'h77);
        @(negedge clk);
        chk("R8 new next cycle", ad_out[1], 8'h99);
        en_n[0] = 1'b1; rd_n[1] = 1'b1; en_n[1] = 1'b1;
        idle(5);
    endtask

    task automatic t_clash();
        do_write(0, 8'h60, 8'h33, 1'b0);
        @(negedge clk);
        ad_in[0] = 8'h60; en_n[0] = 1'b0;
        @(negedge clk);
        ad_in[0] = 8'hEE; wr_n[0] = 1'b0;
        idle(2);
        rd_n[0] = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R9 no drive", {7'b0, ad_oe[0]}, 8'h00);
        end
        chk("R9 err A", {7'b0, err[0]}, 8'h01);
        chk("R9 err B untouched", {7'b0, err[1]}, 8'h00);
        wr_n[0] = 1'b1; rd_n[0] = 1'b1; en_n[0] = 1'b1;
        idle(5);
        do_read(1, 8'h60, 8'h33, "R9 no write");
        chk("R9 err sticky", {7'b0, err[0]}, 8'h01);
        do_reset();
        chk("R1 R9 err cleared", {7'b0, err[0]}, 8'h00);
        do_read(0, 8'h10, 8'h00, "R1 mem cleared again");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset();
        t_cross();
        t_dual_read();
        t_ww();
        t_rw();
        t_clash();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule